// File: doc/BRIEF.md
# CAN Controller Initialization and Configuration Guard

This block holds the control register of a CAN protocol controller and decides when the controller may change its configuration and when it may take part in bus traffic. The host writes the control register, a nominal bit-timing register and a timeout-configuration register through a plain write port. Three hardware events force the controller into initialization: reset, an uncorrectable message-RAM error and entry into bus-off.

While initialization is active, the transmit pin is held recessive and transfer is stopped. The configuration registers open for writing only when both the init bit and the change-enable bit are set. Clearing init relocks them in the same step. After init is released, the block counts sampled receive bits. It lets transfer start only after eleven consecutive recessive bits, which mark the bus as idle. Raising change-enable loads the timeout counter from its preset and holds the Tx and Rx handlers idle.

The write port has no back-pressure. A write is taken on every clock edge where `wr_en` is high, and there is no ready signal. Status comes back on plain level outputs.

Top module: `can_init_ctrl`

## Requirements
- R1: After reset the control word reads 0x01, so only init is set. Its bit layout, from bit 0 upward, is init, cfg_en, monitor, no_retx, test, fd_en, brs_en. The bit-timing and timeout-config registers hold their reset parameters, the timeout counter holds the upper 16 bits of the timeout-config reset value, tx_pin is 1 and xfer_en is 0.
- R2: init is set by a control write with bit 0 = 1, by reset, by hw_ram_err and by hw_bus_off. A hardware request wins over a write that clears init in the same cycle. While init is 1, tx_pin is 1 and xfer_en is 0.
- R3: Setting init changes neither the bit-timing nor the timeout-config register.
- R4: After init is 0, xfer_en rises only after 11 consecutive strobed recessive bits (rx_bit = 1 with bit_strobe = 1). A strobed dominant bit restarts the count, and cycles without a strobe leave it unchanged. Once transfer runs, tx_pin follows tx_core.
- R5: Writes to address 1 (bit timing) and address 2 (timeout config) take effect only while init and cfg_en are both 1. Otherwise they are ignored, as are writes to address 3.
- R6: cfg_en changes only on a control write (address 0) in which the current init or the written init is 1, so one write can set both. cfg_en clears in the same cycle that init clears.
- R7: On the edge where cfg_en goes from 0 to 1, the 16-bit timeout counter loads bits 31:16 of the timeout-config register. It does not reload while cfg_en stays 1.
- R8: tx_hold and rx_hold are 1 exactly while cfg_en is 1.
- R9: test and monitor can be set only by a write made while init and cfg_en are both 1. A write of 0 clears them at any time.
- R10: no_retx, fd_en and brs_en change only by a write made while init and cfg_en are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | 0 control, 1 bit timing, 2 timeout config, 3 unmapped |
| wr_data | input | 32 | Host write data |
| hw_ram_err | input | 1 | Uncorrectable message-RAM error, forces init |
| hw_bus_off | input | 1 | Bus-off entry, forces init |
| bit_strobe | input | 1 | One-cycle strobe per sampled bus bit |
| rx_bit | input | 1 | Sampled receive bit (1 = recessive) |
| tx_core | input | 1 | Transmit bit from the protocol engine |
| ctl_q | output | 7 | Control register |
| nbt_q | output | 32 | Nominal bit-timing register |
| tocc_q | output | 32 | Timeout-config register, preset in bits 31:16 |
| toc_q | output | 16 | Timeout counter value |
| tx_pin | output | 1 | Transmit pin, recessive override applied |
| xfer_en | output | 1 | Message transfer enabled |
| tx_hold | output | 1 | Hold Tx handler idle |
| rx_hold | output | 1 | Hold Rx handler idle |

## Verification
Every register result appears one clock edge after its write or hardware request. tx_pin and xfer_en react combinationally to the registered init bit, so they also settle in that edge. The transfer enable rises on the edge that samples the eleventh strobed recessive bit. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and reads the outputs on the next falling edge. Each expected value therefore belongs to exactly one register update.

// File: rtl/can_init_pkg.sv
package can_init_pkg;
  typedef struct packed {
    logic brs_en;
    logic fd_en;
    logic test;
    logic no_retx;
    logic monitor;
    logic cfg_en;
    logic init;
  } ctl_t;

  localparam int CTL_W  = $bits(ctl_t);
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_NBT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_TOCC = 2'd2;
endpackage

// File: rtl/cic_ctl_reg.sv
module cic_ctl_reg
  import can_init_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctl,
  input  ctl_t wr_val,
  input  logic hw_req,
  output ctl_t ctl_q,
  output logic cfg_rise
);
  ctl_t nx;
  logic unl;

  always_comb begin
    unl = ctl_q.init & ctl_q.cfg_en;
    nx  = ctl_q;
    if (wr_ctl) begin
      nx.init = wr_val.init;
      if (ctl_q.init | wr_val.init) nx.cfg_en = wr_val.cfg_en;
      // set only when unlocked, clear always allowed
      nx.test    = unl ? wr_val.test    : (ctl_q.test & wr_val.test);
      nx.monitor = unl ? wr_val.monitor : (ctl_q.monitor & wr_val.monitor);
      if (unl) begin
        nx.no_retx = wr_val.no_retx;
        nx.fd_en   = wr_val.fd_en;
        nx.brs_en  = wr_val.brs_en;
      end
    end
    if (hw_req) nx.init = 1'b1;
    if (!nx.init) nx.cfg_en = 1'b0;
  end

  assign cfg_rise = nx.cfg_en & ~ctl_q.cfg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      ctl_q.init <= 1'b1;
    end else begin
      ctl_q <= nx;
    end
  end
endmodule

// File: rtl/cic_cfg_regs.sv
module cic_cfg_regs #(
  parameter int          DW       = 32,
  parameter int          TOC_W    = 16,
  parameter logic [31:0] NBT_RST  = 32'h0600_0A03,
  parameter logic [31:0] TOCC_RST = 32'hFFFF_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_nbt,
  input  logic             wr_tocc,
  input  logic [DW-1:0]    wr_data,
  input  logic             load_toc,
  output logic [DW-1:0]    nbt_q,
  output logic [DW-1:0]    tocc_q,
  output logic [TOC_W-1:0] toc_q
);
  localparam int PRE_HI = DW - 1;
  localparam logic [DW-1:0] TOCC_R = DW'(TOCC_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbt_q  <= DW'(NBT_RST);
      tocc_q <= TOCC_R;
      toc_q  <= TOCC_R[PRE_HI -: TOC_W];
    end else begin
      if (wr_nbt)   nbt_q  <= wr_data;
      if (wr_tocc)  tocc_q <= wr_data;
      if (load_toc) toc_q  <= tocc_q[PRE_HI -: TOC_W];
    end
  end
endmodule

// File: rtl/cic_idle_det.sv
module cic_idle_det #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic bit_strobe,
  input  logic rx_bit,
  output logic run_q
);
  localparam int CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);
  localparam logic [CW-1:0] FULL = CW'(IDLE_BITS);

  logic [CW-1:0] cnt;
  logic          hit;

  assign hit = bit_strobe & rx_bit & (cnt == LAST) & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      run_q <= 1'b0;
    end else begin
      if (hold)            cnt <= '0;
      else if (bit_strobe) cnt <= rx_bit ? ((cnt == FULL) ? cnt : cnt + 1'b1) : '0;
      if (hold)     run_q <= 1'b0;
      else if (hit) run_q <= 1'b1;
    end
  end
endmodule

// File: rtl/can_init_ctrl.sv
module can_init_ctrl
  import can_init_pkg::*;
#(
  parameter int          DW        = 32,
  parameter int          TOC_W     = 16,
  parameter int          IDLE_BITS = 11,
  parameter logic [31:0] NBT_RST   = 32'h0600_0A03,
  parameter logic [31:0] TOCC_RST  = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              hw_ram_err,
  input  logic              hw_bus_off,
  input  logic              bit_strobe,
  input  logic              rx_bit,
  input  logic              tx_core,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [DW-1:0]     nbt_q,
  output logic [DW-1:0]     tocc_q,
  output logic [TOC_W-1:0]  toc_q,
  output logic              tx_pin,
  output logic              xfer_en,
  output logic              tx_hold,
  output logic              rx_hold
);
  ctl_t ctl_s;
  logic cfg_rise, unlocked, run_q;
  logic wr_ctl, wr_nbt, wr_tocc;

  assign unlocked = ctl_s.init & ctl_s.cfg_en;
  assign wr_ctl   = wr_en & (wr_addr == ADDR_CTL);
  assign wr_nbt   = wr_en & (wr_addr == ADDR_NBT)  & unlocked;
  assign wr_tocc  = wr_en & (wr_addr == ADDR_TOCC) & unlocked;

  cic_ctl_reg u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctl   (wr_ctl),
    .wr_val   (ctl_t'(wr_data[CTL_W-1:0])),
    .hw_req   (hw_ram_err | hw_bus_off),
    .ctl_q    (ctl_s),
    .cfg_rise (cfg_rise)
  );

  cic_cfg_regs #(
    .DW(DW), .TOC_W(TOC_W), .NBT_RST(NBT_RST), .TOCC_RST(TOCC_RST)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_nbt   (wr_nbt),
    .wr_tocc  (wr_tocc),
    .wr_data  (wr_data),
    .load_toc (cfg_rise),
    .nbt_q    (nbt_q),
    .tocc_q   (tocc_q),
    .toc_q    (toc_q)
  );

  cic_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (ctl_s.init),
    .bit_strobe (bit_strobe),
    .rx_bit     (rx_bit),
    .run_q      (run_q)
  );

  assign ctl_q   = ctl_s;
  assign xfer_en = run_q & ~ctl_s.init;
  assign tx_pin  = xfer_en ? tx_core : 1'b1;
  assign tx_hold = ctl_s.cfg_en;
  assign rx_hold = ctl_s.cfg_en;
endmodule

// File: rtl/can_init_ctrl_chk.sv
module can_init_ctrl_chk #(
  parameter int DW    = 32,
  parameter int TOC_W = 16,
  parameter int CW    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CW-1:0]    ctl_q,
  input logic [DW-1:0]    nbt_q,
  input logic [DW-1:0]    tocc_q,
  input logic [TOC_W-1:0] toc_q,
  input logic             tx_pin,
  input logic             xfer_en,
  input logic             tx_hold,
  input logic             rx_hold,
  input logic             bit_strobe,
  input logic             rx_bit
);
  // R2
  tx_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[0] |-> (tx_pin && !xfer_en));
  // R3
  cfg_kept_on_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[0]) |-> ($stable(nbt_q) && $stable(tocc_q)));
  // R4
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_en) |-> $past(bit_strobe && rx_bit));
  // R5
  nbt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nbt_q) |-> $past(ctl_q[0] && ctl_q[1]));
  // R5
  tocc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tocc_q) |-> $past(ctl_q[0] && ctl_q[1]));
  // R6
  cfg_needs_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[1] |-> ctl_q[0]);
  // R7
  toc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[1]) |-> (toc_q == tocc_q[DW-1 -: TOC_W]));
  // R8
  handler_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[1] |-> (tx_hold && rx_hold));
  // R9
  test_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[4]) |-> $past(ctl_q[0] && ctl_q[1]));
  // R10
  no_retx_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_q[3]) |-> $past(ctl_q[0] && ctl_q[1]));
endmodule

bind can_init_ctrl can_init_ctrl_chk #(.DW(DW), .TOC_W(TOC_W), .CW(can_init_pkg::CTL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .nbt_q(nbt_q), .tocc_q(tocc_q),
  .toc_q(toc_q), .tx_pin(tx_pin), .xfer_en(xfer_en), .tx_hold(tx_hold),
  .rx_hold(rx_hold), .bit_strobe(bit_strobe), .rx_bit(rx_bit)
);

// File: tb/sim_can_init_ctrl.sv
module sim_can_init_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;
  // {addr[1:0], data[7:0], ram_err, bus_off, expected ctl[6:0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {2'd0, 8'h10, 1'b0, 1'b0, 7'h00},
    {2'd0, 8'h03, 1'b0, 1'b0, 7'h03},
    {2'd0, 8'h7F, 1'b0, 1'b0, 7'h7F},
    {2'd0, 8'h6B, 1'b0, 1'b0, 7'h6B},
    {2'd0, 8'h61, 1'b0, 1'b0, 7'h61},
    {2'd0, 8'h7F, 1'b0, 1'b0, 7'h63},
    {2'd0, 8'h77, 1'b0, 1'b0, 7'h77},
    {2'd0, 8'h60, 1'b0, 1'b0, 7'h60},
    {2'd0, 8'h03, 1'b0, 1'b0, 7'h63},
    {2'd0, 8'h77, 1'b0, 1'b0, 7'h77},
    {2'd0, 8'h71, 1'b0, 1'b0, 7'h71},
    {2'd0, 8'h61, 1'b0, 1'b0, 7'h61},
    {2'd0, 8'h01, 1'b0, 1'b0, 7'h61},
    {2'd0, 8'h60, 1'b0, 1'b0, 7'h60},
    {2'd3, 8'h00, 1'b1, 1'b0, 7'h61},
    {2'd0, 8'h60, 1'b0, 1'b0, 7'h60},
    {2'd0, 8'h62, 1'b0, 1'b1, 7'h61},
    {2'd3, 8'h7F, 1'b0, 1'b0, 7'h61}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, hw_ram_err = 1'b0, hw_bus_off = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        bit_strobe = 1'b0, rx_bit = 1'b1, tx_core = 1'b0;
  logic [6:0]  ctl_q;
  logic [31:0] nbt_q, tocc_q;
  logic [15:0] toc_q;
  logic        tx_pin, xfer_en, tx_hold, rx_hold;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_init_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hw_ram_err(hw_ram_err), .hw_bus_off(hw_bus_off), .bit_strobe(bit_strobe),
    .rx_bit(rx_bit), .tx_core(tx_core), .ctl_q(ctl_q), .nbt_q(nbt_q),
    .tocc_q(tocc_q), .toc_q(toc_q), .tx_pin(tx_pin), .xfer_en(xfer_en),
    .tx_hold(tx_hold), .rx_hold(rx_hold)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one write/event, applied from a falling edge, results visible at the next falling edge
  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d,
                      input logic ram, input logic boff);
    wr_en = we; wr_addr = a; wr_data = d; hw_ram_err = ram; hw_bus_off = boff;
    @(negedge clk);
    wr_en = 1'b0; hw_ram_err = 1'b0; hw_bus_off = 1'b0;
  endtask

  task automatic bits(input int n, input logic v);
    for (int i = 0; i < n; i++) begin
      bit_strobe = 1'b1; rx_bit = v;
      @(negedge clk);
    end
    bit_strobe = 1'b0; rx_bit = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctl", 32'(ctl_q), 32'h01);
    chk("R1 nbt", nbt_q, 32'h0600_0A03);
    chk("R1 tocc", tocc_q, 32'hFFFF_0000);
    chk("R1 toc", 32'(toc_q), 32'hFFFF);
    chk("R1 tx_pin/xfer", {30'd0, tx_pin, xfer_en}, 32'b10);

    // control-register table: R2 R6 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      step(1'b1, VEC[i][18:17], 32'(VEC[i][16:9]), VEC[i][8], VEC[i][7]);
      chk($sformatf("R6 R9 R10 R2 ctl vector %0d", i), 32'(ctl_q), 32'(VEC[i][6:0]));
    end

    // R5 locked write ignored (init=1, cfg_en=0)
    step(1'b1, 2'd1, 32'h1111_2222, 1'b0, 1'b0);
    chk("R5 nbt locked", nbt_q, 32'h0600_0A03);
    // R7 unlock loads reset preset
    step(1'b1, 2'd0, 32'h63, 1'b0, 1'b0);
    chk("R7 toc first load", 32'(toc_q), 32'hFFFF);
    chk("R8 holds on", {30'd0, tx_hold, rx_hold}, 32'b11);
    step(1'b1, 2'd1, 32'h1111_2222, 1'b0, 1'b0);
    chk("R5 nbt unlocked", nbt_q, 32'h1111_2222);
    step(1'b1, 2'd2, 32'h1234_0000, 1'b0, 1'b0);
    chk("R5 tocc unlocked", tocc_q, 32'h1234_0000);
    chk("R7 no reload while held", 32'(toc_q), 32'hFFFF);
    step(1'b1, 2'd0, 32'h61, 1'b0, 1'b0);
    chk("R8 holds off", {30'd0, tx_hold, rx_hold}, 32'b00);
    step(1'b1, 2'd0, 32'h63, 1'b0, 1'b0);
    chk("R7 toc reload", 32'(toc_q), 32'h1234);
    // R6 auto relock, R5 write after init cleared ignored
    step(1'b1, 2'd0, 32'h62, 1'b0, 1'b0);
    chk("R6 relock", 32'(ctl_q), 32'h60);
    step(1'b1, 2'd1, 32'h0000_5555, 1'b0, 1'b0);
    chk("R5 nbt after relock", nbt_q, 32'h1111_2222);

    // R4 bus idle wait
    tx_core = 1'b0;
    bits(10, 1'b1);
    chk("R4 10 recessive", {30'd0, xfer_en, tx_pin}, 32'b01);
    bits(1, 1'b0);
    bits(5, 1'b1);
    @(negedge clk);
    bits(5, 1'b1);
    chk("R4 after dominant restart", {30'd0, xfer_en, tx_pin}, 32'b01);
    bits(1, 1'b1);
    chk("R4 11th recessive", {30'd0, xfer_en, tx_pin}, 32'b10);

    // R2 R3 bus-off forces init, config kept
    step(1'b0, 2'd0, 32'h0, 1'b0, 1'b1);
    chk("R2 busoff init", 32'(ctl_q), 32'h61);
    chk("R2 tx recessive", {30'd0, xfer_en, tx_pin}, 32'b01);
    chk("R3 nbt kept", nbt_q, 32'h1111_2222);
    chk("R3 tocc kept", tocc_q, 32'h1234_0000);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule